// File: doc/BRIEF.md
# Dual-Threshold Result Comparator

This block watches a stream of conversion results and compares each new result against a programmable low threshold and a programmable high threshold. A three-bit mode code picks one of six comparisons: above low, at or below low, strictly inside the window, at or above high, below high, or outside the window. In outside mode the result must be at or below low and also at or above high, so it can only match when high is at or below low.

When a valid result matches, two sticky status bits can be set. The flag bit is gated by its own enable, and the interrupt bit is gated by a separate enable. Both bits hold until a write-one-to-clear strobe arrives. If a clear and a new match land in the same cycle, the match wins. The interrupt output is a level that follows the interrupt bit. Sample production and the register file that holds the thresholds and enables are handled outside this block.

Top module: `thresh_cmp`

## Requirements
- R1: After reset both `flag_o` and `irq_o` are 0.
- R2: Mode code 3'd1 matches when the result is strictly greater than `thr_low`. Mode code 3'd2 matches when the result is less than or equal to `thr_low`.
- R3: Mode code 3'd3 matches only when the result is strictly greater than `thr_low` and strictly less than `thr_high`.
- R4: Mode code 3'd5 matches when the result is greater than or equal to `thr_high`. Mode code 3'd6 matches when the result is strictly less than `thr_high`.
- R5: Mode code 3'd7 matches only when the result is both at or below `thr_low` and at or above `thr_high`.
- R6: Mode codes 3'd0 and 3'd4 never match, whatever the result.
- R7: A comparison is made only in a cycle where `res_valid` is high. A matching value on `res_data` while `res_valid` is low sets nothing.
- R8: A match sets `flag_o` only when `flag_en` is high, and sets `irq_o` only when `irq_en` is high. Each enable acts on its own bit alone.
- R9: A set bit stays at 1 until `clr` is high for a cycle with no new match. That bit then reads 0 after that clock edge.
- R10: When `clr` and a match that is enabled for a bit occur in the same cycle, that bit is 1 after the edge.
- R11: The outputs reflect a match one clock edge after the cycle in which `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | High for one cycle when `res_data` holds a new result |
| res_data | input | 12 | Conversion result |
| thr_low | input | 12 | Low threshold |
| thr_high | input | 12 | High threshold |
| mode | input | 3 | Comparison mode code |
| flag_en | input | 1 | Allows a match to set the flag |
| irq_en | input | 1 | Allows a match to set the interrupt |
| clr | input | 1 | Write-one-to-clear strobe for both bits |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong comparison or a wrong mode decode shows at the flag output one edge after the strobed result. The bench therefore checks every mode on both sides of each threshold, and also at equality. A broken hold path shows as a bit that drops without a clear. A broken priority shows as a bit that is 0 after a clear and a match arrive together. Both show within one cycle. A wrong enable routing shows as the two outputs disagreeing on a single match.

// File: rtl/thresh_cmp_pkg.sv
package thresh_cmp_pkg;
  typedef enum logic [2:0] {
    CMP_NONE0  = 3'd0,
    CMP_ABOVE_LO = 3'd1,
    CMP_ATBELOW_LO = 3'd2,
    CMP_INSIDE = 3'd3,
    CMP_NONE4  = 3'd4,
    CMP_ATABOVE_HI = 3'd5,
    CMP_BELOW_HI = 3'd6,
    CMP_OUTSIDE = 3'd7
  } cmp_mode_e;

  localparam int unsigned NUM_STICKY = 2;
  localparam int unsigned IDX_FLAG = 0;
  localparam int unsigned IDX_IRQ  = 1;
endpackage

// File: rtl/thresh_window_match.sv
module thresh_window_match
  import thresh_cmp_pkg::*;
#(
  parameter int unsigned RES_W = 12
) (
  input  logic [RES_W-1:0] value,
  input  logic [RES_W-1:0] lo,
  input  logic [RES_W-1:0] hi,
  input  logic [2:0]       mode,
  output logic             hit
);
  function automatic logic eval_mode(input logic [2:0] m,
                                     input logic [RES_W-1:0] v,
                                     input logic [RES_W-1:0] l,
                                     input logic [RES_W-1:0] h);
    logic gt_lo, ge_hi;
    gt_lo = (v > l);
    ge_hi = (v >= h);
    case (cmp_mode_e'(m))
      CMP_ABOVE_LO:   return gt_lo;
      CMP_ATBELOW_LO: return !gt_lo;
      CMP_INSIDE:     return gt_lo && !ge_hi;
      CMP_ATABOVE_HI: return ge_hi;
      CMP_BELOW_HI:   return !ge_hi;
      CMP_OUTSIDE:    return !gt_lo && ge_hi;
      default:        return 1'b0;
    endcase
  endfunction

  assign hit = eval_mode(mode, value, lo, hi);
endmodule

// File: rtl/thresh_sticky_bit.sv
module thresh_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set && clr) |=> q);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/thresh_cmp.sv
module thresh_cmp
  import thresh_cmp_pkg::*;
#(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic [RES_W-1:0] thr_low,
  input  logic [RES_W-1:0] thr_high,
  input  logic [2:0]       mode,
  input  logic             flag_en,
  input  logic             irq_en,
  input  logic             clr,
  output logic             flag_o,
  output logic             irq_o
);
  logic                  cmp_hit;
  logic                  hit_evt;
  logic [NUM_STICKY-1:0] bit_en;
  logic [NUM_STICKY-1:0] bit_q;

  thresh_window_match #(.RES_W(RES_W)) u_match (
    .value (res_data),
    .lo    (thr_low),
    .hi    (thr_high),
    .mode  (mode),
    .hit   (cmp_hit)
  );

  assign hit_evt = res_valid && cmp_hit;

  always_comb begin
    bit_en           = '0;
    bit_en[IDX_FLAG] = flag_en;
    bit_en[IDX_IRQ]  = irq_en;
  end

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
    thresh_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (hit_evt && bit_en[g]),
      .clr   (clr),
      .q     (bit_q[g])
    );
  end

  assign flag_o = bit_q[IDX_FLAG];
  assign irq_o  = bit_q[IDX_IRQ];

  // R6
  dead_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd4) |-> !cmp_hit);

  // R7
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> !$rose(flag_o) && !$rose(irq_o));

  // R8
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_en && !flag_o) |=> !flag_o);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !irq_o) |=> !irq_o);

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && flag_en) |=> flag_o);
endmodule

// File: tb/thresh_cmp_test.sv
module thresh_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic [11:0] thr_low = '0;
  logic [11:0] thr_high = '0;
  logic [2:0]  mode = '0;
  logic        flag_en = 1'b0;
  logic        irq_en = 1'b0;
  logic        clr = 1'b0;
  logic        flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  thresh_cmp uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .thr_low(thr_low), .thr_high(thr_high), .mode(mode),
    .flag_en(flag_en), .irq_en(irq_en), .clr(clr),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  // {mode, low, high, data, expected}
  localparam int NV = 22;
  localparam logic [39:0] VEC [NV] = '{
    {3'd1, 12'd100, 12'd500, 12'd101, 1'b1},   // R2 above low
    {3'd1, 12'd100, 12'd500, 12'd100, 1'b0},   // R2 equal low
    {3'd2, 12'd100, 12'd500, 12'd100, 1'b1},   // R2 equal low
    {3'd2, 12'd100, 12'd500, 12'd101, 1'b0},   // R2
    {3'd2, 12'd100, 12'd500, 12'd0,   1'b1},   // R2
    {3'd3, 12'd100, 12'd500, 12'd300, 1'b1},   // R3 inside
    {3'd3, 12'd100, 12'd500, 12'd100, 1'b0},   // R3 at low
    {3'd3, 12'd100, 12'd500, 12'd500, 1'b0},   // R3 at high
    {3'd3, 12'd100, 12'd500, 12'd499, 1'b1},   // R3
    {3'd5, 12'd100, 12'd500, 12'd500, 1'b1},   // R4 equal high
    {3'd5, 12'd100, 12'd500, 12'd499, 1'b0},   // R4
    {3'd6, 12'd100, 12'd500, 12'd499, 1'b1},   // R4
    {3'd6, 12'd100, 12'd500, 12'd500, 1'b0},   // R4 equal high
    {3'd6, 12'd100, 12'd500, 12'd4095, 1'b0},  // R4
    {3'd7, 12'd100, 12'd500, 12'd50,  1'b0},   // R5 normal order
    {3'd7, 12'd100, 12'd500, 12'd600, 1'b0},   // R5 normal order
    {3'd7, 12'd500, 12'd100, 12'd300, 1'b1},   // R5 swapped order
    {3'd7, 12'd500, 12'd100, 12'd500, 1'b1},   // R5 edge
    {3'd7, 12'd500, 12'd100, 12'd99,  1'b0},   // R5
    {3'd0, 12'd100, 12'd500, 12'd300, 1'b0},   // R6
    {3'd4, 12'd0,   12'd0,   12'd4095, 1'b0},  // R6
    {3'd4, 12'd4095, 12'd4095, 12'd0, 1'b0}    // R6
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic strobe(input logic [2:0] m, input logic [11:0] lo,
                        input logic [11:0] hi, input logic [11:0] d, input logic c);
    mode = m; thr_low = lo; thr_high = hi; res_data = d;
    res_valid = 1'b1; clr = c;
    @(negedge clk);
    res_valid = 1'b0; clr = 1'b0;
  endtask

  task automatic clear_all();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", flag_o, 1'b0, "flag in reset");
    check("R1", irq_o, 1'b0, "irq in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", flag_o, 1'b0, "flag after reset");
    check("R1", irq_o, 1'b0, "irq after reset");

    flag_en = 1'b1; irq_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][39:37], VEC[i][36:25], VEC[i][24:13], VEC[i][12:1], 1'b0);
      // R11 result visible one edge after the strobe
      check("R2..R6 vector", flag_o, VEC[i][0], $sformatf("flag vec %0d", i));
      check("R8 vector", irq_o, VEC[i][0], $sformatf("irq vec %0d", i));
      clear_all();
      check("R9", flag_o, 1'b0, $sformatf("cleared vec %0d", i));
    end

    // R7 matching data without the strobe
    mode = 3'd1; thr_low = 12'd10; res_data = 12'd200; res_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", flag_o, 1'b0, "no strobe flag");
    check("R7", irq_o, 1'b0, "no strobe irq");

    // R8 flag only
    flag_en = 1'b1; irq_en = 1'b0;
    strobe(3'd1, 12'd10, 12'd0, 12'd200, 1'b0);
    check("R8", flag_o, 1'b1, "flag only: flag");
    check("R8", irq_o, 1'b0, "flag only: irq");
    clear_all();
    // R8 irq only
    flag_en = 1'b0; irq_en = 1'b1;
    strobe(3'd1, 12'd10, 12'd0, 12'd200, 1'b0);
    check("R8", flag_o, 1'b0, "irq only: flag");
    check("R8", irq_o, 1'b1, "irq only: irq");
    clear_all();

    // R9 sticky across non-matching strobes and idle cycles
    flag_en = 1'b1; irq_en = 1'b1;
    strobe(3'd5, 12'd0, 12'd1000, 12'd2000, 1'b0);
    strobe(3'd5, 12'd0, 12'd1000, 12'd5, 1'b0);
    repeat (4) @(negedge clk);
    check("R9", flag_o, 1'b1, "sticky flag");
    check("R9", irq_o, 1'b1, "sticky irq");

    // R10 clear together with a new match
    strobe(3'd5, 12'd0, 12'd1000, 12'd1500, 1'b1);
    check("R10", flag_o, 1'b1, "set wins flag");
    check("R10", irq_o, 1'b1, "set wins irq");
    // R10 clear with a non-matching strobe clears
    strobe(3'd5, 12'd0, 12'd1000, 12'd3, 1'b1);
    check("R9", flag_o, 1'b0, "clear with miss flag");
    check("R9", irq_o, 1'b0, "clear with miss irq");

    // R1 reset mid-run
    strobe(3'd6, 12'd0, 12'd100, 12'd1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", flag_o, 1'b0, "flag after re-reset");
    check("R1", irq_o, 1'b0, "irq after re-reset");

    finish_run();
  end
endmodule